// File: doc/BRIEF.md
# Quad-Slot Issue Group Checker

This block sits at the dispatch point of a four-wide in-order core. Each cycle it is offered up to four decoded instructions in program order. Every instruction comes with a valid bit, a 4-bit class code and a precision flag. The block works out how many of them, counting from the oldest, can leave together as one issue group. It applies the position limits of the four issue slots and steers integer work onto two asymmetric integer pipes. It also enforces the shared-unit and precision limits and cuts the group at the first instruction that cannot join. For each accepted integer instruction it reports which pipe that instruction uses.

The decision itself is combinational: a chain of per-slot stages, each passing a running resource state to the next. The result goes through a one-entry output register with a valid/ready handshake. A request is taken when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the register is empty or the consumer takes the held result in the same cycle. While `out_valid` is high and `out_ready` is low, the held result does not change and no new request is taken. A group size of zero is a legal result and is delivered like any other. Operand dependencies and multi-cycle unit occupancy are handled downstream.

Class codes: 0 plain ALU, 1 shift, 2 compare/edge/array, 3 load, 4 store, 5 conditional branch, 6 call/jump-and-link/unconditional branch, 7 FP add-class (add, sub, move, compare), 8 FP multiply-class, 9 FP divide/square root, 10 and every code from 11 to 15 issue-alone. Slot k uses bits [4k+3:4k] of `slot_cls`. Pipe-select 0 is integer pipe 0 and 1 is integer pipe 1.

Top module: `issue_group_check`

## Requirements
- R1: Classes 0 to 4 may only take slots below INT_SLOTS (default 3). Classes 5, 7 and 8 may take any slot, including the last one.
- R2: The group is the longest run of accepted instructions starting at slot 0. The first invalid or rejected slot ends it, even if later slots are valid. If slot 0 is invalid, the count is 0.
- R3: Shift (1) needs pipe 0 and compare (2) needs pipe 1. Plain ALU (0) takes pipe 0 when both pipes are free and pipe 1 when only pipe 1 is free. Each pipe serves at most one instruction per group. `out_int` marks accepted integer-pipe slots and `out_psel` marks those on pipe 1.
- R4: Once pipe 1 is taken, a later instruction that would need pipe 0 ends the group. So within a group, the pipe-0 instruction always comes before the pipe-1 instruction.
- R5: Issue-alone classes (10 to 15) are accepted only in slot 0, and the group then has exactly one instruction.
- R6: Call-class (6) is accepted only in slot 0. It takes pipe 1 and the control-transfer unit.
- R7: FP add-class and multiply-class operations in one group must share the same `slot_dbl` value. At most MAX_FP (default 2) of them issue together.
- R8: A group holds at most MAX_LSU (default 1) loads/stores and at most MAX_CTI (default 1) control transfers (classes 5 and 6). It also holds at most one FP add-class and at most one multiplier user (classes 8 and 9).
- R9: FP divide (9) is accepted only in slot 0, uses the multiplier, and ignores `slot_dbl`.
- R10: A conditional branch may join a group that already holds a compare.
- R11: `in_ready` is low while `out_valid` is high and `out_ready` is low, and the held result stays unchanged until it is taken.
- R12: After reset `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Request can be taken this cycle |
| slot_vld | input | NSLOT | Per-slot instruction valid |
| slot_cls | input | NSLOT*4 | Per-slot class code |
| slot_dbl | input | NSLOT | Per-slot FP precision, 1 = double |
| out_valid | output | 1 | Result held |
| out_ready | input | 1 | Consumer takes result |
| out_cnt | output | $clog2(NSLOT+1) | Group size |
| out_int | output | NSLOT | Accepted slot uses an integer pipe |
| out_psel | output | NSLOT | Accepted integer slot is on pipe 1 |

## Verification
The bench uses the defaults: four slots, integer classes confined to the first three, two FP operations, one memory operation and one control transfer per group. With these values, four instructions are enough to exhaust both integer pipes, to run into the last-slot restriction, and to hit each single-unit limit. Every cut point, including an invalid slot in the middle, can therefore be placed in every slot position. Back-pressure is held for one cycle while a second request waits at the input.

// File: rtl/igc_pkg.sv
package igc_pkg;

  localparam int CLS_W = 4;

  localparam logic [CLS_W-1:0] K_ALU    = 4'd0;
  localparam logic [CLS_W-1:0] K_SHIFT  = 4'd1;
  localparam logic [CLS_W-1:0] K_CMP    = 4'd2;
  localparam logic [CLS_W-1:0] K_LOAD   = 4'd3;
  localparam logic [CLS_W-1:0] K_STORE  = 4'd4;
  localparam logic [CLS_W-1:0] K_BRANCH = 4'd5;
  localparam logic [CLS_W-1:0] K_CALL   = 4'd6;
  localparam logic [CLS_W-1:0] K_FADD   = 4'd7;
  localparam logic [CLS_W-1:0] K_FMUL   = 4'd8;
  localparam logic [CLS_W-1:0] K_FDIV   = 4'd9;
  localparam logic [CLS_W-1:0] K_SOLO   = 4'd10;

  // Resource needs of one instruction class
  typedef struct packed {
    logic low_only;   // restricted to the integer-capable slots
    logic first_only; // must be slot 0
    logic solo;       // closes the group after itself
    logic p0_only;
    logic p1_only;
    logic p_any;
    logic lsu;
    logic cti;
    logic fpa;
    logic fpm;
    logic fp_prec;    // counts toward the precision rule
  } cls_attr_t;

  // Running group state passed from slot to slot
  typedef struct packed {
    logic       alive;
    logic       p0;
    logic       p1;
    logic [2:0] lsu;
    logic [2:0] cti;
    logic       fpa;
    logic       fpm;
    logic [2:0] fpn;
    logic       fp_any;
    logic       fp_dbl;
  } grp_state_t;

  localparam grp_state_t GRP_EMPTY = '{alive: 1'b1, default: '0};

endpackage

// File: rtl/igc_class_decode.sv
module igc_class_decode
  import igc_pkg::*;
(
  input  logic [CLS_W-1:0] cls,
  output cls_attr_t        attr
);
  always_comb begin
    attr = '0;
    unique case (cls)
      K_ALU:    begin attr.low_only = 1'b1; attr.p_any   = 1'b1; end
      K_SHIFT:  begin attr.low_only = 1'b1; attr.p0_only = 1'b1; end
      K_CMP:    begin attr.low_only = 1'b1; attr.p1_only = 1'b1; end
      K_LOAD,
      K_STORE:  begin attr.low_only = 1'b1; attr.lsu     = 1'b1; end
      K_BRANCH: attr.cti = 1'b1;
      K_CALL:   begin attr.first_only = 1'b1; attr.p1_only = 1'b1; attr.cti = 1'b1; end
      K_FADD:   begin attr.fpa = 1'b1; attr.fp_prec = 1'b1; end
      K_FMUL:   begin attr.fpm = 1'b1; attr.fp_prec = 1'b1; end
      K_FDIV:   begin attr.first_only = 1'b1; attr.fpm = 1'b1; end
      default:  begin attr.first_only = 1'b1; attr.solo = 1'b1; end
    endcase
  end
endmodule

// File: rtl/igc_slot_stage.sv
module igc_slot_stage
  import igc_pkg::*;
#(
  parameter int SLOT      = 0,
  parameter int INT_SLOTS = 3,
  parameter int MAX_FP    = 2,
  parameter int MAX_LSU   = 1,
  parameter int MAX_CTI   = 1
) (
  input  grp_state_t st_in,
  input  logic       vld,
  input  cls_attr_t  attr,
  input  logic       dbl,
  output grp_state_t st_out,
  output logic       take,
  output logic       on_int,
  output logic       on_p1
);
  localparam bit LOW_OK   = (SLOT < INT_SLOTS);
  localparam bit FIRST_OK = (SLOT == 0);

  logic fits;
  logic use_int;
  logic use_p1;

  always_comb begin
    fits    = vld && st_in.alive;
    use_int = 1'b0;
    use_p1  = 1'b0;

    if (attr.low_only && !LOW_OK)     fits = 1'b0;
    if (attr.first_only && !FIRST_OK) fits = 1'b0;

    // pipe 0 may never be taken after pipe 1 in the same group
    if (attr.p0_only) begin
      if (st_in.p0 || st_in.p1) fits = 1'b0;
      else use_int = 1'b1;
    end
    if (attr.p1_only) begin
      if (st_in.p1) fits = 1'b0;
      else begin use_int = 1'b1; use_p1 = 1'b1; end
    end
    if (attr.p_any) begin
      if (!st_in.p0 && !st_in.p1) use_int = 1'b1;
      else if (st_in.p0 && !st_in.p1) begin use_int = 1'b1; use_p1 = 1'b1; end
      else fits = 1'b0;
    end

    if (attr.lsu && int'(st_in.lsu) >= MAX_LSU) fits = 1'b0;
    if (attr.cti && int'(st_in.cti) >= MAX_CTI) fits = 1'b0;
    if (attr.fpa && st_in.fpa) fits = 1'b0;
    if (attr.fpm && st_in.fpm) fits = 1'b0;
    if (attr.fp_prec) begin
      if (st_in.fp_any && (st_in.fp_dbl != dbl)) fits = 1'b0;
      if (int'(st_in.fpn) >= MAX_FP)             fits = 1'b0;
    end

    st_out = st_in;
    if (fits) begin
      if (use_int && !use_p1) st_out.p0 = 1'b1;
      if (use_p1)             st_out.p1 = 1'b1;
      if (attr.lsu) st_out.lsu = st_in.lsu + 3'd1;
      if (attr.cti) st_out.cti = st_in.cti + 3'd1;
      if (attr.fpa) st_out.fpa = 1'b1;
      if (attr.fpm) st_out.fpm = 1'b1;
      if (attr.fp_prec) begin
        st_out.fpn    = st_in.fpn + 3'd1;
        st_out.fp_any = 1'b1;
        st_out.fp_dbl = dbl;
      end
      if (attr.solo) st_out.alive = 1'b0;
    end else begin
      st_out.alive = 1'b0;
    end

    take   = fits;
    on_int = fits && use_int;
    on_p1  = fits && use_p1;
  end
endmodule

// File: rtl/igc_out_reg.sv
module igc_out_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic         vld_q;
  logic [W-1:0] dat_q;
  logic         load;

  assign in_ready  = !vld_q || out_ready;
  assign load      = in_valid && in_ready;
  assign out_valid = vld_q;
  assign out_data  = dat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else if (load) begin
      vld_q <= 1'b1;
      dat_q <= in_data;
    end else if (out_ready) begin
      vld_q <= 1'b0;
    end
  end
endmodule

// File: rtl/issue_group_check.sv
module issue_group_check
  import igc_pkg::*;
#(
  parameter int NSLOT     = 4,
  parameter int INT_SLOTS = 3,
  parameter int MAX_FP    = 2,
  parameter int MAX_LSU   = 1,
  parameter int MAX_CTI   = 1,
  localparam int CNT_W    = $clog2(NSLOT + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [NSLOT-1:0]       slot_vld,
  input  logic [NSLOT*CLS_W-1:0] slot_cls,
  input  logic [NSLOT-1:0]       slot_dbl,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [CNT_W-1:0]       out_cnt,
  output logic [NSLOT-1:0]       out_int,
  output logic [NSLOT-1:0]       out_psel
);
  localparam int RES_W = CNT_W + 2 * NSLOT;

  grp_state_t       chain [NSLOT+1];
  logic [NSLOT-1:0] take;
  logic [NSLOT-1:0] on_int;
  logic [NSLOT-1:0] on_p1;
  logic [CNT_W-1:0] cnt_c;
  logic [RES_W-1:0] res_d;
  logic [RES_W-1:0] res_q;

  assign chain[0] = GRP_EMPTY;

  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    cls_attr_t attr;

    igc_class_decode u_dec (
      .cls  (slot_cls[k*CLS_W +: CLS_W]),
      .attr (attr)
    );

    igc_slot_stage #(
      .SLOT      (k),
      .INT_SLOTS (INT_SLOTS),
      .MAX_FP    (MAX_FP),
      .MAX_LSU   (MAX_LSU),
      .MAX_CTI   (MAX_CTI)
    ) u_stage (
      .st_in  (chain[k]),
      .vld    (slot_vld[k]),
      .attr   (attr),
      .dbl    (slot_dbl[k]),
      .st_out (chain[k+1]),
      .take   (take[k]),
      .on_int (on_int[k]),
      .on_p1  (on_p1[k])
    );
  end

  // accepted slots form a prefix, so the group size is their count
  always_comb begin
    cnt_c = '0;
    for (int k = 0; k < NSLOT; k++) begin
      if (take[k]) cnt_c = cnt_c + CNT_W'(1);
    end
  end

  assign res_d = {cnt_c, on_int, on_p1};

  igc_out_reg #(.W(RES_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (res_d),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (res_q)
  );

  assign {out_cnt, out_int, out_psel} = res_q;

endmodule

// File: rtl/issue_group_check_sva.sv
module issue_group_check_sva #(
  parameter int NSLOT     = 4,
  parameter int INT_SLOTS = 3,
  parameter int CNT_W     = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [CNT_W-1:0] out_cnt,
  input logic [NSLOT-1:0] out_int,
  input logic [NSLOT-1:0] out_psel
);
  logic [NSLOT-1:0] in_grp;
  logic             has_p0, has_p1;
  int               idx_p0, idx_p1;

  always_comb begin
    in_grp = '0;
    has_p0 = 1'b0;
    has_p1 = 1'b0;
    idx_p0 = 0;
    idx_p1 = 0;
    for (int k = 0; k < NSLOT; k++) begin
      if (k < int'(out_cnt)) in_grp[k] = 1'b1;
      if (out_int[k] && !out_psel[k]) begin has_p0 = 1'b1; idx_p0 = k; end
      if (out_psel[k]) begin has_p1 = 1'b1; idx_p1 = k; end
    end
  end

  assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> int'(out_cnt) <= NSLOT);

  assert_pipe_in_group_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_int | out_psel) & ~in_grp) == '0);

  assert_psel_is_int_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_psel & ~out_int) == '0);

  assert_one_per_pipe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones(out_psel) <= 1 && $countones(out_int & ~out_psel) <= 1));

  assert_pipe_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && has_p0 && has_p1) |-> idx_p0 < idx_p1);

  assert_int_low_slots_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_int >> INT_SLOTS) == '0);

  assert_stall_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_cnt) &&
                                   $stable(out_int) && $stable(out_psel)));
endmodule

bind issue_group_check issue_group_check_sva #(
  .NSLOT     (NSLOT),
  .INT_SLOTS (INT_SLOTS),
  .CNT_W     (CNT_W)
) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_cnt   (out_cnt),
  .out_int   (out_int),
  .out_psel  (out_psel)
);

// File: tb/tb_issue_group_check.sv
`timescale 1ns/1ps
module tb_issue_group_check;
  localparam int NSLOT = 4;
  localparam int CNT_W = 3;

  localparam logic [3:0] ALU = 4'd0, SHF = 4'd1, CMP = 4'd2, LD = 4'd3, ST = 4'd4,
                         BR = 4'd5, CALL = 4'd6, FADD = 4'd7, FMUL = 4'd8,
                         FDIV = 4'd9, SOLO = 4'd10;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [3:0]       slot_vld = '0;
  logic [15:0]      slot_cls = '0;
  logic [3:0]       slot_dbl = '0;
  logic             out_valid;
  logic             out_ready = 1'b1;
  logic [CNT_W-1:0] out_cnt;
  logic [3:0]       out_int;
  logic [3:0]       out_psel;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  issue_group_check dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .slot_vld(slot_vld), .slot_cls(slot_cls), .slot_dbl(slot_dbl),
    .out_valid(out_valid), .out_ready(out_ready), .out_cnt(out_cnt),
    .out_int(out_int), .out_psel(out_psel)
  );

  task automatic drive(input logic [3:0] v, input logic [3:0] c0, c1, c2, c3,
                       input logic [3:0] dbl);
    @(negedge clk);
    slot_vld = v;
    slot_cls = {c3, c2, c1, c0};
    slot_dbl = dbl;
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_grp(input string tag, input int cnt,
                            input logic [3:0] iexp, input logic [3:0] pexp);
    total++;
    if (!out_valid || int'(out_cnt) != cnt || out_int !== iexp || out_psel !== pexp) begin
      bad++;
      $display("FAIL %s: got v=%0b cnt=%0d int=%b psel=%b, want v=1 cnt=%0d int=%b psel=%b",
               tag, out_valid, out_cnt, out_int, out_psel, cnt, iexp, pexp);
    end
  endtask

  task automatic t_reset;
    total++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      bad++;
      $display("FAIL R12: got out_valid=%b in_ready=%b, want 0 1", out_valid, in_ready);
    end
  endtask

  task automatic t_slots;
    drive(4'b1111, ALU, FADD, FMUL, BR, 4'b0000);
    expect_grp("R1 branch in last slot", 4, 4'b0001, 4'b0000);
    drive(4'b1111, FADD, FMUL, BR, LD, 4'b0000);
    expect_grp("R1 load in last slot", 3, 4'b0000, 4'b0000);
    drive(4'b1111, ALU, ALU, BR, FADD, 4'b0000);
    expect_grp("R1 mixed to last slot", 4, 4'b0011, 4'b0010);
  endtask

  task automatic t_prefix;
    drive(4'b1110, ALU, ALU, ALU, ALU, 4'b0000);
    expect_grp("R2 slot0 invalid", 0, 4'b0000, 4'b0000);
    drive(4'b1011, ALU, ALU, FADD, FADD, 4'b0000);
    expect_grp("R2 hole at slot2", 2, 4'b0011, 4'b0010);
    drive(4'b0011, ALU, CMP, ALU, ALU, 4'b0000);
    expect_grp("R2 two valid", 2, 4'b0011, 4'b0010);
  endtask

  task automatic t_pipes;
    drive(4'b1111, ALU, ALU, ALU, ALU, 4'b0000);
    expect_grp("R3 alu fills pipes", 2, 4'b0011, 4'b0010);
    drive(4'b0011, ALU, SHF, ALU, ALU, 4'b0000);
    expect_grp("R3 shift after alu", 1, 4'b0001, 4'b0000);
    drive(4'b1111, SHF, CMP, BR, FADD, 4'b0000);
    expect_grp("R3 R10 shift cmp branch", 4, 4'b0011, 4'b0010);
  endtask

  task automatic t_order;
    drive(4'b0011, CMP, SHF, ALU, ALU, 4'b0000);
    expect_grp("R4 shift after cmp", 1, 4'b0001, 4'b0001);
    drive(4'b0011, CMP, ALU, ALU, ALU, 4'b0000);
    expect_grp("R4 alu after cmp", 1, 4'b0001, 4'b0001);
  endtask

  task automatic t_solo;
    drive(4'b0011, SOLO, FADD, ALU, ALU, 4'b0000);
    expect_grp("R5 solo first", 1, 4'b0000, 4'b0000);
    drive(4'b0011, ALU, SOLO, ALU, ALU, 4'b0000);
    expect_grp("R5 solo second", 1, 4'b0001, 4'b0000);
    drive(4'b0011, 4'd13, BR, ALU, ALU, 4'b0000);
    expect_grp("R5 unused code", 1, 4'b0000, 4'b0000);
  endtask

  task automatic t_call;
    drive(4'b0111, CALL, FADD, BR, ALU, 4'b0000);
    expect_grp("R6 call then branch", 2, 4'b0001, 4'b0001);
    drive(4'b0011, ALU, CALL, ALU, ALU, 4'b0000);
    expect_grp("R6 call not first", 1, 4'b0001, 4'b0000);
  endtask

  task automatic t_fp;
    drive(4'b0011, FADD, FMUL, ALU, ALU, 4'b0010);
    expect_grp("R7 mixed precision", 1, 4'b0000, 4'b0000);
    drive(4'b0111, FADD, FMUL, FMUL, ALU, 4'b0111);
    expect_grp("R7 R8 double pair", 2, 4'b0000, 4'b0000);
  endtask

  task automatic t_units;
    drive(4'b0111, LD, ST, ALU, ALU, 4'b0000);
    expect_grp("R8 two memory ops", 1, 4'b0000, 4'b0000);
    drive(4'b0011, BR, BR, ALU, ALU, 4'b0000);
    expect_grp("R8 two branches", 1, 4'b0000, 4'b0000);
    drive(4'b0011, FADD, FADD, ALU, ALU, 4'b0000);
    expect_grp("R8 two fp adds", 1, 4'b0000, 4'b0000);
  endtask

  task automatic t_div;
    drive(4'b0011, FDIV, FMUL, ALU, ALU, 4'b0001);
    expect_grp("R9 div then mul", 1, 4'b0000, 4'b0000);
    drive(4'b0011, FDIV, FADD, ALU, ALU, 4'b0010);
    expect_grp("R9 div then add", 2, 4'b0000, 4'b0000);
    drive(4'b0011, ALU, FDIV, ALU, ALU, 4'b0000);
    expect_grp("R9 div not first", 1, 4'b0001, 4'b0000);
  endtask

  task automatic t_backpressure;
    drive(4'b0001, SHF, ALU, ALU, ALU, 4'b0000);
    expect_grp("R11 first result", 1, 4'b0001, 4'b0000);
    out_ready = 1'b0;
    slot_vld  = 4'b0001;
    slot_cls  = {ALU, ALU, ALU, CMP};
    in_valid  = 1'b1;
    @(posedge clk);
    @(negedge clk);
    total++;
    if (in_ready !== 1'b0) begin
      bad++;
      $display("FAIL R11: in_ready=%b want 0", in_ready);
    end
    expect_grp("R11 held while stalled", 1, 4'b0001, 4'b0000);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    expect_grp("R11 waiting request taken", 1, 4'b0001, 4'b0001);
  endtask

  initial begin
    #(8 * 20000);
    bad++;
    $display("FAIL watchdog: run did not complete, want completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_slots();
    t_prefix();
    t_pipes();
    t_order();
    t_solo();
    t_call();
    t_fp();
    t_units();
    t_div();
    t_backpressure();
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule